// File: doc/BRIEF.md
# Local Interrupt Eligibility and Priority Selector

This block decides, every cycle, whether a hart must take one of its local interrupts and which one. It keeps the pending word in a register of its own and combines it with the per-source enable vector, the delegation mask, the current privilege level and the two global enables (machine and supervisor). Any source whose pending and enable bits are both set is a candidate; a candidate left with machine handling is allowed only below machine privilege or in machine privilege with the machine enable set. A candidate delegated to supervisor handling is allowed only below supervisor privilege or in supervisor privilege with the supervisor enable set. Among allowed candidates the lowest index wins.

Pending bits change through a masked write: the caller supplies a mask and a value, the masked bits of the pending word take the value bits, and the word as it stood before the write is returned in the same cycle. A second register reserves interrupt sources for their drivers: a claim request succeeds only if none of its bits is already reserved, and then its bits are added to the reservation word.

The selection is purely combinational from the registered pending word and the live control inputs; both registers update on the rising clock edge and clear on an active-low asynchronous reset.

Top module: `irq_select`

## Requirements
- R1: While reset is asserted and after it is released, the pending word and the claim word are all zeros and `take_irq` is low.
- R2: A source is a candidate only if its bit is set in both the pending word and `irq_enable`; a pending source with its enable bit clear is never selected.
- R3: A candidate whose `irq_deleg` bit is 0 is allowed when `cur_priv` is 0, 1 or 2, or when `cur_priv` is 3 and `m_gie` is 1; with `cur_priv` 3 and `m_gie` 0 it is not allowed.
- R4: A candidate whose `irq_deleg` bit is 1 is allowed when `cur_priv` is 0 or 2, or when `cur_priv` is 1 and `s_gie` is 1; with `cur_priv` 3 it is never allowed.
- R5: When several candidates are allowed, `irq_cause` is the lowest bit index among them and `take_irq` is high.
- R6: When no candidate is allowed, `take_irq` is low and `irq_cause` is 0.
- R7: When `upd_valid` is high at a rising edge, the pending word after that edge equals `(old & ~upd_mask) | (upd_value & upd_mask)`; during the request cycle `upd_old` shows the pending word before the edge.
- R8: A claim request (`clm_valid` high) with any bit of `clm_bits` already set in the claim word fails: `clm_ok` is low and the claim word is unchanged; otherwise `clm_ok` is high and after the edge the claim word is the old word ORed with `clm_bits`.
- R9: The privilege encoding is 0 user, 1 supervisor, 3 machine; encoding 2 is handled exactly like user.
- R10: Selection is combinational: a pending-word change written at one edge is reflected on `take_irq` and `irq_cause` before the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_enable | input | NUM_IRQ | Per-source enable bits |
| irq_deleg | input | NUM_IRQ | 1 = source handled at supervisor level |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 2 treated as user, 3 machine |
| m_gie | input | 1 | Global machine interrupt enable |
| s_gie | input | 1 | Global supervisor interrupt enable |
| upd_valid | input | 1 | Masked pending-word write request |
| upd_mask | input | NUM_IRQ | Bits of the pending word to replace |
| upd_value | input | NUM_IRQ | New values for the masked bits |
| upd_old | output | NUM_IRQ | Pending word before the write |
| clm_valid | input | 1 | Claim request |
| clm_bits | input | NUM_IRQ | Sources to reserve |
| clm_ok | output | 1 | Claim request succeeds this cycle |
| pend_word | output | NUM_IRQ | Current pending word |
| claim_word | output | NUM_IRQ | Current claim word |
| take_irq | output | 1 | An allowed interrupt is present |
| irq_cause | output | CAUSE_W | Index of the winning source, 0 when none |

## Verification
The assertions assume the control inputs are known (no X) whenever reset is released, and that a claim request and a masked write may arrive in any cycle, independently of each other. They make no assumption about the privilege value, since all four encodings are defined. The stimulus changes inputs only at falling edges, holds `upd_valid` and `clm_valid` for exactly one cycle per request, and drives every privilege encoding including the spare one, so every property is checked under inputs inside these limits.

// File: rtl/irq_select_pkg.sv
package irq_select_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_SPARE = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    // The spare encoding behaves as the least privileged level.
    function automatic priv_e fold_priv(input logic [1:0] raw);
        priv_e p;
        p = priv_e'(raw);
        if (p == PRIV_SPARE) p = PRIV_USER;
        return p;
    endfunction

endpackage

// File: rtl/irq_select_pend_reg.sv
module irq_select_pend_reg #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_IRQ-1:0] wr_mask,
    input  logic [NUM_IRQ-1:0] wr_value,
    output logic [NUM_IRQ-1:0] word_q
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] word;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.word = (st_q.word & ~wr_mask) | (wr_value & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_q = st_q.word;

endmodule

// File: rtl/irq_select_claim_reg.sv
module irq_select_claim_reg #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [NUM_IRQ-1:0] req_bits,
    output logic               grant,
    output logic [NUM_IRQ-1:0] word_q
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] word;
    } claim_state_t;

    claim_state_t st_d, st_q;
    logic         overlap;

    always_comb begin
        st_d    = st_q;
        overlap = |(st_q.word & req_bits);
        grant   = req && !overlap;
        if (grant) begin
            st_d.word = st_q.word | req_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_q = st_q.word;

endmodule

// File: rtl/irq_select_gate.sv
module irq_select_gate
    import irq_select_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] pend,
    input  logic [NUM_IRQ-1:0] enable,
    input  logic [NUM_IRQ-1:0] deleg,
    input  logic [1:0]         priv_raw,
    input  logic               m_gie,
    input  logic               s_gie,
    output logic [NUM_IRQ-1:0] allowed
);

    priv_e              priv;
    logic               mach_ok;
    logic               super_ok;
    logic [NUM_IRQ-1:0] cand;

    always_comb begin
        priv     = fold_priv(priv_raw);
        mach_ok  = (priv != PRIV_MACH) || m_gie;
        super_ok = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && s_gie);
        cand     = pend & enable;
        allowed  = (cand & ~deleg & {NUM_IRQ{mach_ok}})
                 | (cand &  deleg & {NUM_IRQ{super_ok}});
    end

endmodule

// File: rtl/irq_select_pick.sv
module irq_select_pick #(
    parameter int NUM_IRQ = 32,
    localparam int CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0] req,
    output logic               found,
    output logic [CAUSE_W-1:0] idx
);

    // Scan from the top down so the last hit written is the lowest index.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = CAUSE_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_select.sv
module irq_select #(
    parameter int NUM_IRQ = 32,
    localparam int CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic [NUM_IRQ-1:0] irq_deleg,
    input  logic [1:0]         cur_priv,
    input  logic               m_gie,
    input  logic               s_gie,
    input  logic               upd_valid,
    input  logic [NUM_IRQ-1:0] upd_mask,
    input  logic [NUM_IRQ-1:0] upd_value,
    output logic [NUM_IRQ-1:0] upd_old,
    input  logic               clm_valid,
    input  logic [NUM_IRQ-1:0] clm_bits,
    output logic               clm_ok,
    output logic [NUM_IRQ-1:0] pend_word,
    output logic [NUM_IRQ-1:0] claim_word,
    output logic               take_irq,
    output logic [CAUSE_W-1:0] irq_cause
);

    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] allowed;

    irq_select_pend_reg #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_valid),
        .wr_mask  (upd_mask),
        .wr_value (upd_value),
        .word_q   (pend_q)
    );

    irq_select_claim_reg #(.NUM_IRQ(NUM_IRQ)) u_claim (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (clm_valid),
        .req_bits (clm_bits),
        .grant    (clm_ok),
        .word_q   (claim_word)
    );

    irq_select_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
        .pend     (pend_q),
        .enable   (irq_enable),
        .deleg    (irq_deleg),
        .priv_raw (cur_priv),
        .m_gie    (m_gie),
        .s_gie    (s_gie),
        .allowed  (allowed)
    );

    irq_select_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
        .req   (allowed),
        .found (take_irq),
        .idx   (irq_cause)
    );

    assign upd_old   = pend_q;
    assign pend_word = pend_q;

endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
    parameter int NUM_IRQ = 32,
    localparam int CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_enable,
    input logic [NUM_IRQ-1:0] irq_deleg,
    input logic [1:0]         cur_priv,
    input logic               m_gie,
    input logic               s_gie,
    input logic               upd_valid,
    input logic [NUM_IRQ-1:0] upd_mask,
    input logic [NUM_IRQ-1:0] upd_value,
    input logic               clm_valid,
    input logic [NUM_IRQ-1:0] clm_bits,
    input logic               clm_ok,
    input logic [NUM_IRQ-1:0] pend_word,
    input logic [NUM_IRQ-1:0] claim_word,
    input logic               take_irq,
    input logic [CAUSE_W-1:0] irq_cause
);

    p_cand_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (pend_word[irq_cause] && irq_enable[irq_cause]));

    p_mach_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == 2'd3 && !m_gie) |-> !take_irq);

    p_deleg_mach_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == 2'd3 && take_irq) |-> !irq_deleg[irq_cause]);

    p_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !take_irq |-> (irq_cause == '0));

    p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_word & irq_enable) == '0) |-> !take_irq);

    p_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> ((pend_word & $past(upd_mask)) == ($past(upd_value) & $past(upd_mask))));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(pend_word));

    p_claim_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clm_valid && !clm_ok) |=> $stable(claim_word));

    p_claim_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clm_ok |=> ((claim_word & $past(clm_bits)) == $past(clm_bits)));

    p_claim_fail_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clm_valid && !clm_ok) |-> ((claim_word & clm_bits) != '0));

    p_claim_grow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(claim_word) & ~claim_word) == '0));

endmodule

bind irq_select irq_select_chk #(.NUM_IRQ(NUM_IRQ)) u_irq_select_chk (.*);

// File: tb/irq_select_bench.sv
`timescale 1ns/1ps
module irq_select_bench;

    localparam int N  = 32;
    localparam int CW = 5;

    typedef struct packed {
        logic [N-1:0]  pend;
        logic [N-1:0]  en;
        logic [N-1:0]  deleg;
        logic [1:0]    priv;
        logic          mg;
        logic          sg;
        logic          take;
        logic [CW-1:0] cause;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0880, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b1, 1'b0, 1'b1, 5'd7},  // R5
        '{32'h0000_0880, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b0, 1'b0, 1'b0, 5'd0},  // R3
        '{32'h0000_0880, 32'h0000_0800, 32'h0, 2'd3, 1'b1, 1'b0, 1'b1, 5'd11}, // R2
        '{32'h0000_0222, 32'hFFFF_FFFF, 32'h2, 2'd1, 1'b0, 1'b0, 1'b1, 5'd5},  // R3
        '{32'h0000_0222, 32'hFFFF_FFFF, 32'h2, 2'd1, 1'b0, 1'b1, 1'b1, 5'd1},  // R4
        '{32'h0000_0002, 32'hFFFF_FFFF, 32'h2, 2'd3, 1'b1, 1'b1, 1'b0, 5'd0},  // R4
        '{32'h0000_0002, 32'hFFFF_FFFF, 32'h2, 2'd0, 1'b0, 1'b0, 1'b1, 5'd1},  // R4
        '{32'h0000_0002, 32'hFFFF_FFFF, 32'h2, 2'd2, 1'b0, 1'b0, 1'b1, 5'd1},  // R9
        '{32'h0000_0002, 32'hFFFF_FFFF, 32'h2, 2'd1, 1'b0, 1'b0, 1'b0, 5'd0},  // R9
        '{32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1, 5'd31}, // R5
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b1, 1'b1, 1'b0, 5'd0},  // R6
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 2'd3, 1'b1, 1'b1, 1'b0, 5'd0}   // R2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_enable = '0, irq_deleg = '0;
    logic [1:0]    cur_priv = 2'd3;
    logic          m_gie = 1'b0, s_gie = 1'b0;
    logic          upd_valid = 1'b0;
    logic [N-1:0]  upd_mask = '0, upd_value = '0;
    logic [N-1:0]  upd_old;
    logic          clm_valid = 1'b0;
    logic [N-1:0]  clm_bits = '0;
    logic          clm_ok;
    logic [N-1:0]  pend_word, claim_word;
    logic          take_irq;
    logic [CW-1:0] irq_cause;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    irq_select #(.NUM_IRQ(N)) u_irq_select (.*);

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_pend(input logic [N-1:0] m, input logic [N-1:0] v);
        @(negedge clk);
        upd_valid = 1'b1; upd_mask = m; upd_value = v;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++; n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pend in reset", pend_word, '0);
        check("R1 claim in reset", claim_word, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 take after reset", N'(take_irq), '0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            irq_enable = VECS[k].en; irq_deleg = VECS[k].deleg;
            cur_priv = VECS[k].priv; m_gie = VECS[k].mg; s_gie = VECS[k].sg;
            write_pend('1, VECS[k].pend);
            check($sformatf("R7 vec%0d pend", k), pend_word, VECS[k].pend);
            check($sformatf("R2-5 vec%0d take", k), N'(take_irq), N'(VECS[k].take));
            check($sformatf("R5 vec%0d cause", k), N'(irq_cause), N'(VECS[k].cause));
        end

        // R7 masked update and old word
        write_pend('1, 32'hF0F0_F0F0);
        @(negedge clk);
        upd_valid = 1'b1; upd_mask = 32'h0000_FFFF; upd_value = 32'h1234_5678;
        #1 check("R7 old word", upd_old, 32'hF0F0_F0F0);
        @(negedge clk);
        upd_valid = 1'b0;
        check("R7 masked result", pend_word, 32'hF0F0_5678);

        // R10 same-cycle reflection right after the writing edge
        irq_enable = '1; irq_deleg = '0; cur_priv = 2'd3; m_gie = 1'b1;
        @(negedge clk);
        upd_valid = 1'b1; upd_mask = '1; upd_value = 32'h0000_0008;
        @(posedge clk);
        #1 check("R10 take after edge", N'(take_irq), N'(1));
        check("R10 cause after edge", N'(irq_cause), N'(3));
        @(negedge clk);
        upd_valid = 1'b0;

        // R8 claim
        @(negedge clk);
        clm_valid = 1'b1; clm_bits = 32'h5;
        #1 check("R8 ok first", N'(clm_ok), N'(1));
        @(negedge clk);
        clm_valid = 1'b0;
        check("R8 word first", claim_word, 32'h5);
        clm_valid = 1'b1; clm_bits = 32'h6;
        #1 check("R8 overlap rejected", N'(clm_ok), N'(0));
        @(negedge clk);
        clm_valid = 1'b0;
        check("R8 word unchanged", claim_word, 32'h5);
        clm_valid = 1'b1; clm_bits = 32'hA;
        #1 check("R8 ok disjoint", N'(clm_ok), N'(1));
        @(negedge clk);
        clm_valid = 1'b0;
        check("R8 word merged", claim_word, 32'hF);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pend cleared", pend_word, '0);
        check("R1 claim cleared", claim_word, '0);
        check("R1 take cleared", N'(take_irq), '0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule